// File: doc/BRIEF.md
# Saturating Event Statistics Counter Bank

This block keeps a small bank of event counters for a 10/100 Ethernet port. Physical-layer conditions (a false carrier, a link drop and a jabber cut-off) arrive as one-cycle pulses and are counted directly. Frame outcomes are counted only when a transmit-done or receive-done pulse arrives. The status flags given with that pulse decide which counter, if any, advances.

Each counter stops at its all-ones value instead of wrapping. The counters start at zero after reset, and no write path exists. Software reads a counter through a strobe-and-address port, and the read also clears that counter. An event that arrives in the same cycle as a read of its counter is kept as the counter's new value of one, so no event is lost.

The number of counters built is a parameter. Register indices are fixed, so a smaller bank leaves its upper indices unmapped.

Top module: `stat_counter_bank`

## Requirements
- R1: Counter 0 (false carrier), counter 1 (link drop) and counter 2 (jabber) each advance by exactly one per cycle in which their pulse input is high.
- R2: A counter that holds 16'hFFFF stays at 16'hFFFF when further events arrive.
- R3: A cycle with `rd_en` high and `rd_addr` below NUM_CNT loads that counter's value into `rd_data` at the next clock edge and clears the counter. `rd_data` keeps its value while `rd_en` is low.
- R4: After reset, every counter reads zero and `rd_data` is zero. No input can set a counter to a value other than zero or its current value plus one.
- R5: Frame counters change only in a cycle with a done pulse. Counter 3 advances on `tx_done` with `tx_ok` high. Counter 4 advances on `rx_done` with `rx_good` high and `rx_nores` low. Counter 5 advances on `rx_done` with `rx_good` low. The status flags alone change nothing.
- R6: Counter 6 (receive drop, no resources) advances on `rx_done` with `rx_nores` high. It does not advance when `save_bad_en` is high and `rx_good` is low.
- R7: If a counter's event and a read of that counter fall in the same cycle, the read returns the old value and the counter becomes 1.
- R8: A read strobe with `rd_addr` at or above NUM_CNT returns zero and leaves every counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_false_carrier | input | 1 | False-carrier event pulse |
| ev_link_drop | input | 1 | Link disconnect event pulse |
| ev_jabber | input | 1 | Jabber event pulse |
| tx_done | input | 1 | Transmit frame finished |
| tx_ok | input | 1 | Transmit status: success |
| rx_done | input | 1 | Receive frame finished |
| rx_good | input | 1 | Receive status: frame free of errors |
| rx_nores | input | 1 | Receive status: dropped for lack of resources |
| save_bad_en | input | 1 | Save-bad-frames mode |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W (4) | Counter index |
| rd_data | output | CNT_W (16) | Registered read data |

## Verification
The hardest states to reach are the top of a counter's range and a read that lands in the same cycle as an event. For saturation, the bench sends a run of false-carrier pulses longer than the counter's range with no read in between. It then checks that the read returns all ones and that a second read returns zero. For the collision case, the bench raises an event pulse and the read strobe on the same clock edge. It then reads again to confirm that the counter was left at one. The drop counter's save-bad exclusion needs a bad frame that also has no resources, sent once with the mode on and once with it off.

// File: rtl/stat_pkg.sv
package stat_pkg;
   // fixed register indices
   localparam int IDX_FALSE_CARRIER = 0;
   localparam int IDX_LINK_DROP     = 1;
   localparam int IDX_JABBER        = 2;
   localparam int IDX_TX_OK         = 3;
   localparam int IDX_RX_OK         = 4;
   localparam int IDX_RX_BAD        = 5;
   localparam int IDX_RX_DROP       = 6;
   localparam int EV_N              = 7;

   typedef struct packed {
      logic tx_done;
      logic tx_ok;
      logic rx_done;
      logic rx_good;
      logic rx_nores;
   } frame_stat_t;
endpackage

// File: rtl/stat_event_qual.sv
module stat_event_qual
   import stat_pkg::*;
(
   input  logic              ev_false_carrier,
   input  logic              ev_link_drop,
   input  logic              ev_jabber,
   input  frame_stat_t       fs,
   input  logic              save_bad_en,
   output logic [EV_N-1:0]   ev
);
   always_comb begin
      ev = '0;
      ev[IDX_FALSE_CARRIER] = ev_false_carrier;
      ev[IDX_LINK_DROP]     = ev_link_drop;
      ev[IDX_JABBER]        = ev_jabber;
      ev[IDX_TX_OK]         = fs.tx_done & fs.tx_ok;
      ev[IDX_RX_OK]         = fs.rx_done & fs.rx_good & ~fs.rx_nores;
      ev[IDX_RX_BAD]        = fs.rx_done & ~fs.rx_good;
      // a bad frame kept by save-bad mode is not a resource drop
      ev[IDX_RX_DROP]       = fs.rx_done & fs.rx_nores & ~(save_bad_en & ~fs.rx_good);
   end
endmodule

// File: rtl/stat_sat_counter.sv
module stat_sat_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] q
);
   localparam logic [CNT_W-1:0] MAXV = '1;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic at_max;
   assign at_max = (q == MAXV);

   always_ff @(posedge clk) begin
      if (!rst_n)              q <= '0;
      else if (clr)            q <= inc ? ONE : '0;
      else if (inc && !at_max) q <= q + ONE;
   end

   p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && q != MAXV) |=> (q == $past(q) + ONE));
   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (q == MAXV && !clr) |=> (q == MAXV));
   p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !inc) |=> (q == '0));
   p_keep_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && inc) |=> (q == ONE));
   p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> $stable(q));
endmodule

// File: rtl/stat_read_port.sv
module stat_read_port #(
   parameter int NUM_CNT = 7,
   parameter int CNT_W   = 16,
   parameter int ADDR_W  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        rd_addr,
   input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
   output logic [NUM_CNT-1:0]       clr,
   output logic [CNT_W-1:0]         rd_data
);
   localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_CNT);

   logic             hit;
   logic [CNT_W-1:0] sel;

   assign hit = rd_en && ({1'b0, rd_addr} < LIMIT);

   always_comb begin
      sel = '0;
      clr = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if ({1'b0, rd_addr} == (ADDR_W+1)'(i)) begin
            sel    = cnt_flat[i*CNT_W +: CNT_W];
            clr[i] = hit;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= hit ? sel : '0;
   end

   p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !hit) |=> (rd_data == '0));
   p_unmapped_noclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (clr == '0));
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
   p_one_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr));
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank
   import stat_pkg::*;
#(
   parameter int NUM_CNT = 7,
   parameter int CNT_W   = 16,
   parameter int ADDR_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_false_carrier,
   input  logic              ev_link_drop,
   input  logic              ev_jabber,
   input  logic              tx_done,
   input  logic              tx_ok,
   input  logic              rx_done,
   input  logic              rx_good,
   input  logic              rx_nores,
   input  logic              save_bad_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data
);
   generate
      if (NUM_CNT < 1 || NUM_CNT > EV_N) begin : g_bad_num
         $error("NUM_CNT must be between 1 and %0d", EV_N);
      end
      if ((1 << ADDR_W) < NUM_CNT) begin : g_bad_addr
         $error("ADDR_W too small for NUM_CNT");
      end
      if (CNT_W < 2) begin : g_bad_w
         $error("CNT_W must be at least 2");
      end
   endgenerate

   frame_stat_t              fs;
   logic [EV_N-1:0]          ev;
   logic [NUM_CNT-1:0]       clr;
   logic [NUM_CNT*CNT_W-1:0] cnt_flat;

   assign fs = '{tx_done: tx_done, tx_ok: tx_ok, rx_done: rx_done,
                 rx_good: rx_good, rx_nores: rx_nores};

   stat_event_qual u_qual (
      .ev_false_carrier (ev_false_carrier),
      .ev_link_drop     (ev_link_drop),
      .ev_jabber        (ev_jabber),
      .fs               (fs),
      .save_bad_en      (save_bad_en),
      .ev               (ev)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
         stat_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ev[gi]),
            .clr   (clr[gi]),
            .q     (cnt_flat[gi*CNT_W +: CNT_W])
         );
      end
   endgenerate

   stat_read_port #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .cnt_flat (cnt_flat),
      .clr      (clr),
      .rd_data  (rd_data)
   );

   // frame counters stay put without a done pulse (R5)
   generate
      if (NUM_CNT > IDX_TX_OK) begin : g_a_tx
         p_tx_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!tx_done && !clr[IDX_TX_OK]) |=> $stable(cnt_flat[IDX_TX_OK*CNT_W +: CNT_W]));
      end
      if (NUM_CNT > IDX_RX_DROP) begin : g_a_drop
         p_savebad_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (save_bad_en && !rx_good && !clr[IDX_RX_DROP])
               |=> $stable(cnt_flat[IDX_RX_DROP*CNT_W +: CNT_W]));
      end
   endgenerate
endmodule

// File: tb/stat_counter_bank_tb.sv
module stat_counter_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_false_carrier = 0, ev_link_drop = 0, ev_jabber = 0;
   logic        tx_done = 0, tx_ok = 0, rx_done = 0, rx_good = 0, rx_nores = 0;
   logic        save_bad_en = 0, rd_en = 0;
   logic [3:0]  rd_addr = '0;
   logic [15:0] rd_data;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   stat_counter_bank u_dut (
      .clk(clk), .rst_n(rst_n),
      .ev_false_carrier(ev_false_carrier), .ev_link_drop(ev_link_drop),
      .ev_jabber(ev_jabber), .tx_done(tx_done), .tx_ok(tx_ok),
      .rx_done(rx_done), .rx_good(rx_good), .rx_nores(rx_nores),
      .save_bad_en(save_bad_en), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data)
   );

   // {index, pulse count, expected read}
   typedef struct packed { logic [3:0] idx; logic [7:0] n; logic [15:0] exp; } vec_t;
   localparam vec_t VECS [8] = '{
      '{4'd0, 8'd3,  16'd3},  '{4'd1, 8'd1,  16'd1},
      '{4'd2, 8'd5,  16'd5},  '{4'd3, 8'd4,  16'd4},
      '{4'd4, 8'd7,  16'd7},  '{4'd5, 8'd2,  16'd2},
      '{4'd6, 8'd6,  16'd6},  '{4'd0, 8'd20, 16'd20}
   };
   localparam string VREQ [8] = '{"R1","R1","R1","R5","R5","R5","R6","R1"};

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // one-cycle pulse of the given kind, driven at the falling edge
   task automatic set_ev(input int k, input logic v);
      case (k)
         0: ev_false_carrier = v;
         1: ev_link_drop = v;
         2: ev_jabber = v;
         3: begin tx_done = v; tx_ok = v; end
         4: begin rx_done = v; rx_good = v; end
         5: begin rx_done = v; rx_good = 1'b0; end
         6: begin rx_done = v; rx_nores = v; rx_good = v; end
         default: ;
      endcase
   endtask

   task automatic pulse(input int k, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); set_ev(k, 1'b1);
         @(negedge clk); set_ev(k, 1'b0);
      end
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk); rd_en = 1'b1; rd_addr = a;
      @(negedge clk); rd_en = 1'b0; d = rd_data;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R4 rd_data after reset", rd_data, 16'd0);
      for (int a = 0; a < 7; a++) begin
         rd(4'(a), d); check("R4 counter zero after reset", d, 16'd0);
      end

      // table walk
      for (int v = 0; v < 8; v++) begin
         pulse(int'(VECS[v].idx), int'(VECS[v].n));
         rd(VECS[v].idx, d); check(VREQ[v], d, VECS[v].exp);
         rd(VECS[v].idx, d); check("R3 cleared by read", d, 16'd0);
      end

      // R3 hold while no strobe
      pulse(2, 3); rd(4'd2, d);
      repeat (4) @(negedge clk);
      check("R3 rd_data held", rd_data, 16'd3);

      // R5 flags without done pulse do nothing
      @(negedge clk); tx_ok = 1; rx_good = 1; rx_nores = 1;
      @(negedge clk); tx_ok = 0; rx_good = 0; rx_nores = 0;
      @(negedge clk); tx_done = 1; tx_ok = 0;
      @(negedge clk); tx_done = 0;
      rd(4'd3, d); check("R5 tx flags w/o done", d, 16'd0);
      rd(4'd4, d); check("R5 rx flags w/o done", d, 16'd0);
      rd(4'd6, d); check("R5 nores w/o done", d, 16'd0);

      // R6 save-bad exclusion
      save_bad_en = 1;
      @(negedge clk); rx_done = 1; rx_nores = 1; rx_good = 0;
      @(negedge clk); rx_done = 0; rx_nores = 0;
      rd(4'd6, d); check("R6 bad frame kept, no drop count", d, 16'd0);
      rd(4'd5, d); check("R5 bad frame counted", d, 16'd1);
      save_bad_en = 0;
      @(negedge clk); rx_done = 1; rx_nores = 1; rx_good = 0;
      @(negedge clk); rx_done = 0; rx_nores = 0;
      rd(4'd6, d); check("R6 drop counted w/o save-bad", d, 16'd1);
      rd(4'd5, d); check("R5 bad frame counted again", d, 16'd1);

      // R7 event and read in the same cycle
      pulse(1, 4);
      @(negedge clk); rd_en = 1; rd_addr = 4'd1; ev_link_drop = 1;
      @(negedge clk); rd_en = 0; ev_link_drop = 0; d = rd_data;
      check("R7 read returns old value", d, 16'd4);
      rd(4'd1, d); check("R7 counter left at one", d, 16'd1);

      // R8 unmapped address
      pulse(0, 2);
      rd(4'd9, d); check("R8 unmapped reads zero", d, 16'd0);
      rd(4'd7, d); check("R8 first unmapped index", d, 16'd0);
      rd(4'd0, d); check("R8 no side effect", d, 16'd2);

      // R2 saturation
      @(negedge clk); ev_false_carrier = 1;
      repeat (65540) @(negedge clk);
      ev_false_carrier = 0;
      rd(4'd0, d); check("R2 saturated value", d, 16'hFFFF);
      rd(4'd0, d); check("R2 cleared after saturated read", d, 16'd0);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule